// File: doc/BRIEF.md
# Trap Entry Status Stacking Unit

This block holds the control-register state that a software trap instruction touches. It keeps a live status word and two levels of saved status, plus two levels of saved return address. The live status has three bits: a stack-mode bit, an interrupt-enable bit and a condition flag. When the decode stage raises a trap request, the block updates everything in one clock edge. The saved state moves down one level. The live interrupt-enable and condition bits are cleared. The return address is recorded. The handler address is already on the vector output during the request cycle.

Software can also move values to and from the four control registers through a write port and a read port. A write is registered. A read is combinational and is chosen by a separate read selector. The block does not contain fetch, decode, the return-from-trap path, interrupt logic or memory. The pipeline around it uses the vector output to redirect fetch.

Top module: `trap_stack_unit`

## Requirements
- R1: After reset, all four control registers read 0.
- R2: On a trap edge, the second-level status (selector 1: stack-mode bit 7, interrupt-enable bit 6, condition bit 0) takes the old first-level backup. The first-level backup (selector 0, bits 15, 14 and 8 in the same order) takes the old live status.
- R3: On a trap edge, the live interrupt-enable (selector 0 bit 6) and condition (selector 0 bit 0) bits become 0. The live stack-mode bit (selector 0 bit 7) keeps its value.
- R4: On a trap edge, the second-level return address (selector 3) takes the old first-level return address (selector 2). Selector 2 takes the trap instruction address plus 4, with the low two bits forced to 0.
- R5: `vec_out` is combinational and equals 0x40 + 4 × `trap_num` for every trap number 0 to 15. For example, trap 2 gives 0x48 and trap 15 gives 0x7C.
- R6: A control-register write with no trap in the same cycle updates the register named by `cr_wr_sel` at the next clock edge. The selector values are: 0 = live and backup status, 1 = second-level status, 2 = first-level return address, 3 = second-level return address. `cr_rd_data` shows the register named by `cr_rd_sel` in the same cycle.
- R7: Unimplemented bits read 0 and ignore writes. Selectors 0 and 1 implement only the bit positions listed in R2 and R3. Bits 1:0 of selectors 2 and 3 always read 0.
- R8: If a trap request and a control-register write fall in the same cycle, the trap update takes effect and the write is dropped.
- R9: With no trap request and no write, all control registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap instruction accepted this cycle |
| trap_num | input | 4 | Trap number from the instruction |
| trap_pc | input | 32 | Address of the trap instruction |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_wr_sel | input | 2 | Control register to write |
| cr_wr_data | input | 32 | Write data |
| cr_rd_sel | input | 2 | Control register to read |
| cr_rd_data | output | 32 | Read data, combinational |
| vec_out | output | 32 | Handler vector for `trap_num` |

## Verification
The hardest cases to reach from the ports are those where the state before a trap has the live and first-level status bits different and the second-level status already non-zero. Only then does a broken shift order show up as a wrong value, not as a value that happens to be right. Two directed preloads set up exactly that: each sets the two levels opposite to one another and then traps. A seeded random phase then mixes traps, writes and traps that collide with writes, so that many different stack contents enter the shift. Every read selector is compared against a bench model after every cycle.

// File: rtl/trap_stack_pkg.sv
package trap_stack_pkg;

  localparam int unsigned XLEN     = 32;
  localparam int unsigned SM_BIT   = 7;
  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned CC_BIT   = 0;
  localparam int unsigned BKP_OFS  = 8;

  // three implemented status bits
  typedef struct packed {
    logic sm;
    logic ie;
    logic cc;
  } stat_t;

  typedef enum logic [1:0] {
    SEL_STAT  = 2'd0,
    SEL_STAT2 = 2'd1,
    SEL_RET   = 2'd2,
    SEL_RET2  = 2'd3
  } cr_sel_e;

  // pull a status triple out of a word, starting at bit offset ofs
  function automatic stat_t stat_from_word(logic [XLEN-1:0] w, int unsigned ofs);
    stat_t s;
    s.sm = w[ofs + SM_BIT];
    s.ie = w[ofs + IE_BIT];
    s.cc = w[ofs + CC_BIT];
    return s;
  endfunction

  // place a status triple into an otherwise zero word
  function automatic logic [XLEN-1:0] stat_to_word(stat_t s, int unsigned ofs);
    logic [XLEN-1:0] w;
    w = '0;
    w[ofs + SM_BIT] = s.sm;
    w[ofs + IE_BIT] = s.ie;
    w[ofs + CC_BIT] = s.cc;
    return w;
  endfunction

  // live status after trap entry
  function automatic stat_t stat_on_trap(stat_t s);
    stat_t r;
    r.sm = s.sm;
    r.ie = 1'b0;
    r.cc = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/tsu_status_stack.sv
module tsu_status_stack
  import trap_stack_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trap_fire,
  input  logic  wr_pair_en,
  input  logic  wr_lvl2_en,
  input  stat_t wr_live,
  input  stat_t wr_bkp,
  input  stat_t wr_lvl2,
  output stat_t live_q,
  output stat_t bkp_q,
  output stat_t lvl2_q
);

  stat_t live_d, bkp_d, lvl2_d;

  always_comb begin
    live_d = live_q;
    bkp_d  = bkp_q;
    lvl2_d = lvl2_q;
    if (trap_fire) begin
      lvl2_d = bkp_q;
      bkp_d  = live_q;
      live_d = stat_on_trap(live_q);
    end else begin
      if (wr_pair_en) begin
        live_d = wr_live;
        bkp_d  = wr_bkp;
      end
      if (wr_lvl2_en) begin
        lvl2_d = wr_lvl2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      bkp_q  <= '0;
      lvl2_q <= '0;
    end else begin
      live_q <= live_d;
      bkp_q  <= bkp_d;
      lvl2_q <= lvl2_d;
    end
  end

endmodule

// File: rtl/tsu_pc_stack.sv
module tsu_pc_stack #(
  parameter int unsigned XW        = 32,
  parameter int unsigned ALIGN_LOG = 2,
  parameter int unsigned RET_STEP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_fire,
  input  logic [XW-1:0] trap_pc,
  input  logic          wr_ret_en,
  input  logic          wr_ret2_en,
  input  logic [XW-1:0] wr_data,
  output logic [XW-1:0] ret_q,
  output logic [XW-1:0] ret2_q
);

  localparam logic [XW-1:0] ALIGN_MASK = ~((XW'(1) << ALIGN_LOG) - XW'(1));

  function automatic logic [XW-1:0] align_addr(logic [XW-1:0] a);
    return a & ALIGN_MASK;
  endfunction

  function automatic logic [XW-1:0] return_addr(logic [XW-1:0] pc);
    return align_addr(pc + XW'(RET_STEP));
  endfunction

  logic [XW-1:0] ret_d, ret2_d;

  always_comb begin
    ret_d  = ret_q;
    ret2_d = ret2_q;
    if (trap_fire) begin
      ret2_d = ret_q;
      ret_d  = return_addr(trap_pc);
    end else begin
      if (wr_ret_en)  ret_d  = align_addr(wr_data);
      if (wr_ret2_en) ret2_d = align_addr(wr_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_q  <= '0;
      ret2_q <= '0;
    end else begin
      ret_q  <= ret_d;
      ret2_q <= ret2_d;
    end
  end

endmodule

// File: rtl/tsu_vector_gen.sv
module tsu_vector_gen #(
  parameter int unsigned       XW        = 32,
  parameter int unsigned       NUM_W     = 4,
  parameter int unsigned       STEP_LOG  = 2,
  parameter logic [XW-1:0]     BASE      = 32'h40
) (
  input  logic [NUM_W-1:0] num,
  output logic [XW-1:0]    vec
);

  function automatic logic [XW-1:0] handler_addr(logic [NUM_W-1:0] n);
    return BASE + (XW'(n) << STEP_LOG);
  endfunction

  assign vec = handler_addr(num);

endmodule

// File: rtl/tsu_cr_read.sv
module tsu_cr_read
  import trap_stack_pkg::*;
(
  input  logic [1:0]      sel,
  input  stat_t           live,
  input  stat_t           bkp,
  input  stat_t           lvl2,
  input  logic [XLEN-1:0] ret,
  input  logic [XLEN-1:0] ret2,
  output logic [XLEN-1:0] data
);

  always_comb begin
    data = '0;
    unique case (cr_sel_e'(sel))
      SEL_STAT:  data = stat_to_word(live, 0) | stat_to_word(bkp, BKP_OFS);
      SEL_STAT2: data = stat_to_word(lvl2, 0);
      SEL_RET:   data = ret;
      SEL_RET2:  data = ret2;
      default:   data = '0;
    endcase
  end

endmodule

// File: rtl/trap_stack_unit.sv
module trap_stack_unit
  import trap_stack_pkg::*;
#(
  parameter int unsigned NUM_W    = 4,
  parameter int unsigned STEP_LOG = 2,
  parameter int unsigned RET_STEP = 4,
  parameter logic [31:0] VEC_BASE = 32'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic [NUM_W-1:0] trap_num,
  input  logic [31:0]      trap_pc,
  input  logic             cr_wr_en,
  input  logic [1:0]       cr_wr_sel,
  input  logic [31:0]      cr_wr_data,
  input  logic [1:0]       cr_rd_sel,
  output logic [31:0]      cr_rd_data,
  output logic [31:0]      vec_out
);

  // named internal events for the checker
  logic  trap_fire;
  logic  wr_fire;
  logic  wr_pair_en, wr_lvl2_en, wr_ret_en, wr_ret2_en;
  stat_t live_st, bkp_st, lvl2_st;
  stat_t wr_live, wr_bkp, wr_lvl2;
  logic [31:0] ret_q, ret2_q;

  assign trap_fire = trap_req;
  assign wr_fire   = cr_wr_en & ~trap_req;

  assign wr_pair_en = wr_fire && (cr_sel_e'(cr_wr_sel) == SEL_STAT);
  assign wr_lvl2_en = wr_fire && (cr_sel_e'(cr_wr_sel) == SEL_STAT2);
  assign wr_ret_en  = wr_fire && (cr_sel_e'(cr_wr_sel) == SEL_RET);
  assign wr_ret2_en = wr_fire && (cr_sel_e'(cr_wr_sel) == SEL_RET2);

  assign wr_live = stat_from_word(cr_wr_data, 0);
  assign wr_bkp  = stat_from_word(cr_wr_data, BKP_OFS);
  assign wr_lvl2 = stat_from_word(cr_wr_data, 0);

  tsu_status_stack u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_fire  (trap_fire),
    .wr_pair_en (wr_pair_en),
    .wr_lvl2_en (wr_lvl2_en),
    .wr_live    (wr_live),
    .wr_bkp     (wr_bkp),
    .wr_lvl2    (wr_lvl2),
    .live_q     (live_st),
    .bkp_q      (bkp_st),
    .lvl2_q     (lvl2_st)
  );

  tsu_pc_stack #(
    .XW        (32),
    .ALIGN_LOG (STEP_LOG),
    .RET_STEP  (RET_STEP)
  ) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_fire  (trap_fire),
    .trap_pc    (trap_pc),
    .wr_ret_en  (wr_ret_en),
    .wr_ret2_en (wr_ret2_en),
    .wr_data    (cr_wr_data),
    .ret_q      (ret_q),
    .ret2_q     (ret2_q)
  );

  tsu_vector_gen #(
    .XW       (32),
    .NUM_W    (NUM_W),
    .STEP_LOG (STEP_LOG),
    .BASE     (VEC_BASE)
  ) u_vec (
    .num (trap_num),
    .vec (vec_out)
  );

  tsu_cr_read u_rd (
    .sel  (cr_rd_sel),
    .live (live_st),
    .bkp  (bkp_st),
    .lvl2 (lvl2_st),
    .ret  (ret_q),
    .ret2 (ret2_q),
    .data (cr_rd_data)
  );

endmodule

// File: rtl/trap_stack_checker.sv
module trap_stack_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        trap_req,
  input logic [3:0]  trap_num,
  input logic [31:0] trap_pc,
  input logic        cr_wr_en,
  input logic [1:0]  cr_wr_sel,
  input logic [31:0] cr_wr_data,
  input logic [31:0] vec_out,
  input logic [2:0]  live_st,
  input logic [2:0]  bkp_st,
  input logic [2:0]  lvl2_st,
  input logic [31:0] ret_q,
  input logic [31:0] ret2_q
);

  // R2: status shifts one level down on trap
  assert_status_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (lvl2_st == $past(bkp_st)) && (bkp_st == $past(live_st)));

  // R3: live ie/cond cleared, stack-mode kept
  assert_live_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (live_st[1:0] == 2'b00) && (live_st[2] == $past(live_st[2])));

  // R4: return-address stack shift
  assert_ret_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (ret2_q == $past(ret_q)) &&
                 (ret_q == ((($past(trap_pc) + 32'd4) >> 2) << 2)));

  // R5: vector offset from base is four times the trap number
  assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> ((vec_out - 32'h40) >> 2) == {28'd0, trap_num} && vec_out[1:0] == 2'b00);

  // R6: second-level return address write lands on next edge
  assert_write_ret2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wr_en && !trap_req && cr_wr_sel == 2'd3) |=> ret2_q[31:2] == $past(cr_wr_data[31:2]));

  // R7: return addresses stay word aligned
  assert_ret_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_q[1:0] == 2'b00) && (ret2_q[1:0] == 2'b00));

  // R8: trap beats a colliding write
  assert_trap_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cr_wr_en) |=> (bkp_st == $past(live_st)) && (ret2_q == $past(ret_q)));

  // R9: idle cycles hold every register
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && !cr_wr_en) |=> $stable(live_st) && $stable(bkp_st) && $stable(lvl2_st)
                                 && $stable(ret_q) && $stable(ret2_q));

endmodule

bind trap_stack_unit trap_stack_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_req   (trap_req),
  .trap_num   (trap_num),
  .trap_pc    (trap_pc),
  .cr_wr_en   (cr_wr_en),
  .cr_wr_sel  (cr_wr_sel),
  .cr_wr_data (cr_wr_data),
  .vec_out    (vec_out),
  .live_st    (live_st),
  .bkp_st     (bkp_st),
  .lvl2_st    (lvl2_st),
  .ret_q      (ret_q),
  .ret2_q     (ret2_q)
);

// File: tb/sim_trap_stack_unit.sv
`timescale 1ns/1ps
module sim_trap_stack_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 1'b0;
  logic [3:0]  trap_num = '0;
  logic [31:0] trap_pc = '0;
  logic        cr_wr_en = 1'b0;
  logic [1:0]  cr_wr_sel = '0;
  logic [31:0] cr_wr_data = '0;
  logic [1:0]  cr_rd_sel = '0;
  logic [31:0] cr_rd_data;
  logic [31:0] vec_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model: {sm, ie, cond}
  logic [2:0]  m_live = '0, m_bkp = '0, m_lvl2 = '0;
  logic [31:0] m_ret = '0, m_ret2 = '0;

  always #10 clk = ~clk;  // 50 MHz

  trap_stack_unit u0 (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_num(trap_num),
    .trap_pc(trap_pc), .cr_wr_en(cr_wr_en), .cr_wr_sel(cr_wr_sel),
    .cr_wr_data(cr_wr_data), .cr_rd_sel(cr_rd_sel), .cr_rd_data(cr_rd_data),
    .vec_out(vec_out)
  );

  function automatic logic [31:0] exp_vec(logic [3:0] n);
    return 32'd64 + 32'd4 * {28'd0, n};
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] sel);
    logic [31:0] r;
    r = 32'd0;
    case (sel)
      2'd0: begin
        r[15] = m_bkp[2];  r[14] = m_bkp[1];  r[8] = m_bkp[0];
        r[7]  = m_live[2]; r[6]  = m_live[1]; r[0] = m_live[0];
      end
      2'd1: begin r[7] = m_lvl2[2]; r[6] = m_lvl2[1]; r[0] = m_lvl2[0]; end
      2'd2: r = m_ret;
      default: r = m_ret2;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic read_check(logic [1:0] sel, logic [31:0] exp, string tag);
    cr_rd_sel = sel;
    #1;
    check(tag, cr_rd_data, exp, $sformatf("read sel=%0d", sel));
  endtask

  task automatic check_all(string stat_tag, string lvl2_tag, string pc_tag);
    read_check(2'd0, exp_read(2'd0), stat_tag);
    read_check(2'd1, exp_read(2'd1), lvl2_tag);
    read_check(2'd2, exp_read(2'd2), pc_tag);
    read_check(2'd3, exp_read(2'd3), pc_tag);
  endtask

  // one cycle of stimulus, entered and left just after a falling edge
  task automatic step(bit t, logic [3:0] n, logic [31:0] pc, bit w,
                      logic [1:0] s, logic [31:0] d);
    trap_req = t; trap_num = n; trap_pc = pc;
    cr_wr_en = w; cr_wr_sel = s; cr_wr_data = d;
    #1;
    if (t) check("R5", vec_out, exp_vec(n), "vector");
    @(posedge clk);
    if (t) begin
      m_lvl2 = m_bkp;
      m_bkp  = m_live;
      m_live = {m_live[2], 2'b00};
      m_ret2 = m_ret;
      m_ret  = (pc + 32'd4) & 32'hFFFF_FFFC;
    end else if (w) begin
      case (s)
        2'd0: begin m_live = {d[7], d[6], d[0]}; m_bkp = {d[15], d[14], d[8]}; end
        2'd1: m_lvl2 = {d[7], d[6], d[0]};
        2'd2: m_ret  = d & 32'hFFFF_FFFC;
        default: m_ret2 = d & 32'hFFFF_FFFC;
      endcase
    end
    @(negedge clk);
    trap_req = 1'b0; cr_wr_en = 1'b0;
    if (t && w)      check_all("R8", "R8", "R8");
    else if (t)      check_all("R3", "R2", "R4");
    else if (w)      check_all("R6", "R6", "R6");
    else             check_all("R9", "R9", "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    read_check(2'd0, 32'd0, "R1");
    read_check(2'd1, 32'd0, "R1");
    read_check(2'd2, 32'd0, "R1");
    read_check(2'd3, 32'd0, "R1");

    // R7: write all ones, unimplemented bits read 0
    step(0, 4'd0, 32'd0, 1, 2'd0, 32'hFFFF_FFFF);
    read_check(2'd0, 32'h0000_C1C1, "R7");
    step(0, 4'd0, 32'd0, 1, 2'd1, 32'hFFFF_FFFF);
    read_check(2'd1, 32'h0000_00C1, "R7");
    step(0, 4'd0, 32'd0, 1, 2'd2, 32'hFFFF_FFFF);
    read_check(2'd2, 32'hFFFF_FFFC, "R7");

    // First preload: backup set, live clear
    step(0, 4'd0, 32'd0, 1, 2'd1, 32'd0);
    step(0, 4'd0, 32'd0, 1, 2'd0, 32'h0000_C100);
    step(0, 4'd0, 32'd0, 1, 2'd3, 32'd0);
    step(0, 4'd0, 32'd0, 1, 2'd2, 32'd42);
    step(1, 4'd2, 32'h0000_1000, 0, 2'd0, 32'd0);
    read_check(2'd1, 32'h0000_00C1, "R2");
    read_check(2'd0, 32'h0000_0000, "R3");
    read_check(2'd3, 32'h0000_0028, "R4");
    read_check(2'd2, 32'h0000_1004, "R4");

    // Second preload: live set, backup clear
    step(0, 4'd0, 32'd0, 1, 2'd1, 32'h0000_00C1);
    step(0, 4'd0, 32'd0, 1, 2'd0, 32'h0000_00C1);
    step(1, 4'd2, 32'h0000_2002, 0, 2'd0, 32'd0);
    read_check(2'd1, 32'h0000_0000, "R2");
    read_check(2'd0, 32'h0000_C180, "R3");
    read_check(2'd2, 32'h0000_2004, "R4");

    // R5: vector extremes
    step(1, 4'd0, 32'h0000_0100, 0, 2'd0, 32'd0);
    step(1, 4'd15, 32'hFFFF_FFFC, 0, 2'd0, 32'd0);
    trap_num = 4'd15; #1;
    check("R5", vec_out, 32'h0000_007C, "vector 15");

    // R8: collision
    step(0, 4'd0, 32'd0, 1, 2'd0, 32'h0000_C1C1);
    step(1, 4'd7, 32'h0000_3000, 1, 2'd0, 32'd0);
    // R9: idle
    step(0, 4'd0, 32'd0, 0, 2'd0, 32'd0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      bit t, w;
      t = ($urandom % 3) == 0;
      w = ($urandom % 2) == 0;
      step(t, 4'($urandom), $urandom, w, 2'($urandom), $urandom);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule